// File: doc/BRIEF.md
# Segmented String Transfer Sequencer

This block runs the element loop of string-style memory operations for a machine with 16-bit offsets and 16-bit segment bases. A single start pulse loads a source offset, a destination offset, an element counter and an accumulator value. The same pulse selects an operation, a repeat mode, the element size and the stepping direction. The sequencer then walks memory one element at a time over a byte-wide request/acknowledge port. It forms every 20-bit physical address from a segment base and an offset, and it updates the offsets, the counter, the accumulator and three compare flags as it goes.

Five element operations are available: move (copy source to destination), compare (source against destination), scan (accumulator against destination), load (source into accumulator) and store (accumulator to destination). A repeat mode can run the element loop until the counter runs out. Two conditional modes also stop on the equality result of each compare or scan. When the operation ends, the sequencer raises a one-cycle done pulse. The final offsets, counter, accumulator and flags then stay visible on the outputs until the next start.

Top module: `strseq_top`

## Requirements
- R1: A byte access at offset `o` in segment `s` drives `memAddr = (s*16 + o) mod 2^20`. The source side uses `srcSeg` and the destination side uses `dstSeg`.
- R2: After each element, an offset that the operation steps moves up when `dirDown=0` and down when `dirDown=1`. The step is 1 with `wordMode=0` and 2 with `wordMode=1`, and it wraps modulo 2^16.
- R3: A word element takes two byte accesses: first the low byte at offset `o`, then the high byte at offset `(o+1) mod 2^16` in the same segment.
- R4: Move (`opSel=0`) writes the source element to the destination, steps both offsets and leaves the flags unchanged.
- R5: Compare (`opSel=1`) reads the source element and then the destination element, and steps both offsets. It sets zf=0, cf=0, sf=0 when source > destination (unsigned). It sets zf=0, cf=1, sf=1 when source < destination, and zf=1, cf=0, sf=0 when they are equal.
- R6: Scan (`opSel=2`) compares the accumulator (its low byte in byte mode) with the destination element, with the same flag rules as R5. It steps only the destination offset and leaves the accumulator unchanged.
- R7: Load (`opSel=3`) puts the source element into the accumulator and steps only the source offset. In byte mode the high byte of the accumulator is kept.
- R8: Store (`opSel=4`) writes the accumulator (its low byte in byte mode) to the destination, steps only the destination offset and leaves the flags unchanged.
- R9: With `repSel=0` exactly one element is processed and the counter keeps its loaded value.
- R10: With `repSel=1` the loop repeats, decrementing the counter by 1 per element, and stops when the counter reaches 0.
- R11: With `repSel=2` a compare or scan also stops after an element that was not equal. With `repSel=3` it also stops after an element that was equal. For move, load and store, modes 2 and 3 behave like mode 1.
- R12: If `repSel` is nonzero and `countIn` is 0 at start, no memory request is made and `done` is high in the cycle after the start edge.
- R13: `memReq` together with `memAddr`, `memWe` and `memWdata` holds steady until the cycle in which `memAck` is high. Each acknowledge completes one byte.
- R14: `done` is a single-cycle pulse, after which `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| opSel | input | 3 | 0 move, 1 compare, 2 scan, 3 load, 4 store |
| repSel | input | 2 | 0 single, 1 repeat, 2 repeat while equal, 3 repeat while not equal |
| wordMode | input | 1 | 1: 16-bit elements, 0: bytes |
| dirDown | input | 1 | 1: offsets step downward |
| srcSeg | input | 16 | Source segment base (held while busy) |
| dstSeg | input | 16 | Destination segment base (held while busy) |
| srcOffIn | input | 16 | Source offset loaded at start |
| dstOffIn | input | 16 | Destination offset loaded at start |
| countIn | input | 16 | Element counter loaded at start |
| accIn | input | 16 | Accumulator loaded at start |
| srcOff | output | 16 | Current source offset |
| dstOff | output | 16 | Current destination offset |
| count | output | 16 | Current element counter |
| acc | output | 16 | Current accumulator |
| zf | output | 1 | Equal flag |
| cf | output | 1 | Below flag |
| sf | output | 1 | Sign flag of the compare |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| memReq | output | 1 | Byte access request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 20 | Physical byte address |
| memWdata | output | 8 | Write byte |
| memAck | input | 1 | Access complete |
| memRdata | input | 8 | Read byte, valid with memAck |

## Verification
Moves are run upward in byte mode and downward in word mode, with a destination that starts at offset 0. Together they show the step direction, the step size and offset wrap-around inside a segment. A single word load at offset FFFF in segment FFFF isolates the high-byte wrap and the 20-bit truncation of the address. Compare and scan sequences are built so that the first mismatch or the first match falls in the middle of a longer counter. Other sequences run the counter out, and a further case sets source above destination. These patterns separate counter-based termination from flag-based termination and check all three flag outcomes. A zero-count start, a store placed after a scan, and a move under a conditional mode cover the skip path, flag preservation and the rule that conditions apply only to compare and scan.

// File: rtl/strseq_pkg.sv
`timescale 1ns/1ps
package strseq_pkg;
  localparam int OFF_W     = 16;
  localparam int SEG_SHIFT = 4;
  localparam int PA_W      = OFF_W + SEG_SHIFT;
  localparam int BYTE_W    = 8;
  localparam int ELEM_W    = 2 * BYTE_W;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_CMP   = 3'd1,
    OP_SCAN  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    REP_NONE = 2'd0,
    REP_ALL  = 2'd1,
    REP_EQ   = 2'd2,
    REP_NE   = 2'd3
  } rep_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDSRC,
    ST_RDDST,
    ST_WRDST,
    ST_STEP,
    ST_DONE
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRegs;
    logic capSrc;
    logic capDst;
    logic hiByte;
    logic addrDst;
    logic wrAcc;
    logic useAcc;
    logic stepSrc;
    logic stepDst;
    logic decCount;
    logic setFlags;
    logic loadAcc;
    logic wordMode;
    logic dirDown;
  } dpCtl_t;
endpackage

// File: rtl/strseq_ctrl.sv
`timescale 1ns/1ps
module strseq_ctrl
  import strseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       opSel,
  input  logic [1:0]       repSel,
  input  logic             wordMode,
  input  logic             dirDown,
  input  logic [OFF_W-1:0] countIn,
  input  logic             memAck,
  input  logic             countOne,
  input  logic             cmpEq,
  output dpCtl_t           ctl,
  output logic             memReq,
  output logic             memWe,
  output logic             busy,
  output logic             done,
  output op_e              opNow
);

  state_e state;
  op_e    cfgOp;
  rep_e   cfgRep;
  logic   cfgWord;
  logic   cfgDir;
  logic   hiSel;

  logic   byteLast;
  logic   isCmp;
  logic   condStop;
  op_e    reqOp;
  rep_e   reqRep;

  assign reqOp    = op_e'(opSel);
  assign reqRep   = rep_e'(repSel);
  assign byteLast = !cfgWord || hiSel;
  assign isCmp    = (cfgOp == OP_CMP) || (cfgOp == OP_SCAN);
  assign condStop = isCmp && (((cfgRep == REP_EQ) && !cmpEq) ||
                              ((cfgRep == REP_NE) &&  cmpEq));

  function automatic state_e firstState(op_e op);
    case (op)
      OP_SCAN:  return ST_RDDST;
      OP_STORE: return ST_WRDST;
      default:  return ST_RDSRC;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cfgOp   <= OP_MOVE;
      cfgRep  <= REP_NONE;
      cfgWord <= 1'b0;
      cfgDir  <= 1'b0;
      hiSel   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            cfgOp   <= reqOp;
            cfgRep  <= reqRep;
            cfgWord <= wordMode;
            cfgDir  <= dirDown;
            hiSel   <= 1'b0;
            if ((reqRep != REP_NONE) && (countIn == '0))
              state <= ST_DONE;
            else
              state <= firstState(reqOp);
          end
        end
        ST_RDSRC: begin
          if (memAck) begin
            if (!byteLast) begin
              hiSel <= 1'b1;
            end else begin
              hiSel <= 1'b0;
              case (cfgOp)
                OP_CMP:  state <= ST_RDDST;
                OP_LOAD: state <= ST_STEP;
                default: state <= ST_WRDST;
              endcase
            end
          end
        end
        ST_RDDST, ST_WRDST: begin
          if (memAck) begin
            if (!byteLast) begin
              hiSel <= 1'b1;
            end else begin
              hiSel <= 1'b0;
              state <= ST_STEP;
            end
          end
        end
        ST_STEP: begin
          if ((cfgRep == REP_NONE) || countOne || condStop)
            state <= ST_DONE;
          else
            state <= firstState(cfgOp);
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.wordMode = cfgWord;
    ctl.dirDown  = cfgDir;
    ctl.hiByte   = hiSel;
    ctl.wrAcc    = (cfgOp == OP_STORE);
    ctl.useAcc   = (cfgOp == OP_SCAN);
    ctl.loadRegs = (state == ST_IDLE) && start;
    case (state)
      ST_RDSRC: ctl.capSrc = memAck;
      ST_RDDST: begin
        ctl.addrDst = 1'b1;
        ctl.capDst  = memAck;
      end
      ST_WRDST: ctl.addrDst = 1'b1;
      ST_STEP: begin
        ctl.stepSrc  = (cfgOp != OP_SCAN) && (cfgOp != OP_STORE);
        ctl.stepDst  = (cfgOp != OP_LOAD);
        ctl.decCount = (cfgRep != REP_NONE);
        ctl.setFlags = isCmp;
        ctl.loadAcc  = (cfgOp == OP_LOAD);
      end
      default: ;
    endcase
  end

  assign memReq = (state == ST_RDSRC) || (state == ST_RDDST) || (state == ST_WRDST);
  assign memWe  = (state == ST_WRDST);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_DONE);
  assign opNow  = cfgOp;

  // R13: a pending request keeps its direction until acknowledged
  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

  // R12: a repeated start with an empty counter skips all memory traffic
  p_zero_skip_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && start && (repSel != 2'd0) && (countIn == '0))
      |=> (done && !memReq));

  // R14: completion is a single-cycle pulse
  p_done_pulse_r14: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: the last counted element ends the loop
  p_rep_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_STEP) && (cfgRep != REP_NONE) && countOne) |=> done);

endmodule

// File: rtl/strseq_dpath.sv
`timescale 1ns/1ps
module strseq_dpath
  import strseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [OFF_W-1:0]  srcSeg,
  input  logic [OFF_W-1:0]  dstSeg,
  input  logic [OFF_W-1:0]  srcOffIn,
  input  logic [OFF_W-1:0]  dstOffIn,
  input  logic [OFF_W-1:0]  countIn,
  input  logic [ELEM_W-1:0] accIn,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [PA_W-1:0]   memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic [OFF_W-1:0]  srcOff,
  output logic [OFF_W-1:0]  dstOff,
  output logic [OFF_W-1:0]  count,
  output logic [ELEM_W-1:0] acc,
  output logic              zf,
  output logic              cf,
  output logic              sf,
  output logic              countOne,
  output logic              cmpEq
);

  localparam logic [OFF_W-1:0] STEP_BYTE = OFF_W'(1);
  localparam logic [OFF_W-1:0] STEP_WORD = OFF_W'(2);

  logic [ELEM_W-1:0] tmpSrc;
  logic [ELEM_W-1:0] tmpDst;
  logic [OFF_W-1:0]  stepAmt;
  logic [OFF_W-1:0]  selOff;
  logic [OFF_W-1:0]  byteOff;
  logic [OFF_W-1:0]  selSeg;
  logic [ELEM_W-1:0] wrSrc;
  logic [ELEM_W-1:0] lhs;
  logic              cmpLt;

  function automatic logic [OFF_W-1:0] nextOff(logic [OFF_W-1:0] off,
                                               logic [OFF_W-1:0] amt,
                                               logic down);
    return down ? (off - amt) : (off + amt);
  endfunction

  // address forming
  assign stepAmt = ctl.wordMode ? STEP_WORD : STEP_BYTE;
  assign selOff  = ctl.addrDst ? dstOff : srcOff;
  assign selSeg  = ctl.addrDst ? dstSeg : srcSeg;
  assign byteOff = selOff + OFF_W'(ctl.hiByte);
  assign memAddr = {selSeg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, byteOff};

  // write data
  assign wrSrc    = ctl.wrAcc ? acc : tmpSrc;
  assign memWdata = ctl.hiByte ? wrSrc[ELEM_W-1:BYTE_W] : wrSrc[BYTE_W-1:0];

  // comparison of the left operand against the destination element
  assign lhs = ctl.useAcc ? acc : tmpSrc;
  always_comb begin
    if (ctl.wordMode) begin
      cmpEq = (lhs == tmpDst);
      cmpLt = (lhs < tmpDst);
    end else begin
      cmpEq = (lhs[BYTE_W-1:0] == tmpDst[BYTE_W-1:0]);
      cmpLt = (lhs[BYTE_W-1:0] <  tmpDst[BYTE_W-1:0]);
    end
  end

  assign countOne = (count == OFF_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmpSrc <= '0;
      tmpDst <= '0;
    end else begin
      if (ctl.capSrc) begin
        if (ctl.hiByte) tmpSrc[ELEM_W-1:BYTE_W] <= memRdata;
        else            tmpSrc[BYTE_W-1:0]      <= memRdata;
      end
      if (ctl.capDst) begin
        if (ctl.hiByte) tmpDst[ELEM_W-1:BYTE_W] <= memRdata;
        else            tmpDst[BYTE_W-1:0]      <= memRdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcOff <= '0;
      dstOff <= '0;
      count  <= '0;
      acc    <= '0;
    end else if (ctl.loadRegs) begin
      srcOff <= srcOffIn;
      dstOff <= dstOffIn;
      count  <= countIn;
      acc    <= accIn;
    end else begin
      if (ctl.stepSrc)  srcOff <= nextOff(srcOff, stepAmt, ctl.dirDown);
      if (ctl.stepDst)  dstOff <= nextOff(dstOff, stepAmt, ctl.dirDown);
      if (ctl.decCount) count  <= count - OFF_W'(1);
      if (ctl.loadAcc) begin
        if (ctl.wordMode) acc            <= tmpSrc;
        else              acc[BYTE_W-1:0] <= tmpSrc[BYTE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zf <= 1'b0;
      cf <= 1'b0;
      sf <= 1'b0;
    end else if (ctl.setFlags) begin
      zf <= cmpEq;
      cf <= cmpLt;
      sf <= cmpLt;
    end
  end

  // R5: equal and below never coexist, and sign follows below
  p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(zf && cf) && (sf == cf));

  // R10: a repeating element removes exactly one from the counter
  p_count_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.decCount && !ctl.loadRegs) |=> (count != $past(count)));

endmodule

// File: rtl/strseq_top.sv
`timescale 1ns/1ps
module strseq_top
  import strseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  opSel,
  input  logic [1:0]  repSel,
  input  logic        wordMode,
  input  logic        dirDown,
  input  logic [15:0] srcSeg,
  input  logic [15:0] dstSeg,
  input  logic [15:0] srcOffIn,
  input  logic [15:0] dstOffIn,
  input  logic [15:0] countIn,
  input  logic [15:0] accIn,
  output logic [15:0] srcOff,
  output logic [15:0] dstOff,
  output logic [15:0] count,
  output logic [15:0] acc,
  output logic        zf,
  output logic        cf,
  output logic        sf,
  output logic        busy,
  output logic        done,
  output logic        memReq,
  output logic        memWe,
  output logic [19:0] memAddr,
  output logic [7:0]  memWdata,
  input  logic        memAck,
  input  logic [7:0]  memRdata
);

  dpCtl_t ctl;
  logic   countOne;
  logic   cmpEq;
  op_e    opNow;

  strseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opSel    (opSel),
    .repSel   (repSel),
    .wordMode (wordMode),
    .dirDown  (dirDown),
    .countIn  (countIn),
    .memAck   (memAck),
    .countOne (countOne),
    .cmpEq    (cmpEq),
    .ctl      (ctl),
    .memReq   (memReq),
    .memWe    (memWe),
    .busy     (busy),
    .done     (done),
    .opNow    (opNow)
  );

  strseq_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .srcSeg   (srcSeg),
    .dstSeg   (dstSeg),
    .srcOffIn (srcOffIn),
    .dstOffIn (dstOffIn),
    .countIn  (countIn),
    .accIn    (accIn),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .srcOff   (srcOff),
    .dstOff   (dstOff),
    .count    (count),
    .acc      (acc),
    .zf       (zf),
    .cf       (cf),
    .sf       (sf),
    .countOne (countOne),
    .cmpEq    (cmpEq)
  );

  // R13: address and write byte hold while a request waits
  p_addr_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memWdata)));

  // R8: a store never disturbs the flags
  p_store_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && (opNow == OP_STORE)) |=> $stable({zf, cf, sf}));

endmodule

// File: tb/strseq_top_bench.sv
`timescale 1ns/1ps
module strseq_top_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [2:0]  opSel;
  logic [1:0]  repSel;
  logic        wordMode, dirDown;
  logic [15:0] srcSeg, dstSeg, srcOffIn, dstOffIn, countIn, accIn;
  logic [15:0] srcOff, dstOff, count, acc;
  logic        zf, cf, sf, busy, done;
  logic        memReq, memWe, memAck;
  logic [19:0] memAddr;
  logic [7:0]  memWdata, memRdata;

  always #2.5 clk = ~clk;

  strseq_top u_strseq_top (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .repSel(repSel),
    .wordMode(wordMode), .dirDown(dirDown), .srcSeg(srcSeg), .dstSeg(dstSeg),
    .srcOffIn(srcOffIn), .dstOffIn(dstOffIn), .countIn(countIn), .accIn(accIn),
    .srcOff(srcOff), .dstOff(dstOff), .count(count), .acc(acc),
    .zf(zf), .cf(cf), .sf(sf), .busy(busy), .done(done),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  int nChecks = 0;
  int nFails  = 0;
  int accessCount = 0;
  bit finished = 0;

  logic [7:0] mem [logic [19:0]];

  typedef struct {
    logic [19:0] addr;
    logic [7:0]  data;
    string       tag;
  } wrItem_t;
  wrItem_t expQ[$];

  function automatic logic [19:0] pa(logic [15:0] seg, logic [15:0] off);
    return {seg, 4'b0} + {4'b0, off};
  endfunction

  function automatic logic [7:0] peek(logic [19:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ 8'hC3;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushWr(logic [19:0] a, logic [7:0] d, string tag);
    wrItem_t it;
    it.addr = a; it.data = d; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // memory model: acknowledge one cycle after a request is seen
  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
    end else if (memReq && !memAck) begin
      memAck <= 1'b1;
      accessCount++;
      if (memWe) mem[memAddr] = memWdata;
      else       memRdata <= peek(memAddr);
    end else begin
      memAck <= 1'b0;
    end
  end

  // scoreboard monitor and request-hold observer
  logic        pending = 1'b0;
  logic [19:0] seenAddr;
  always @(negedge clk) begin
    if (rstN && memReq) begin
      if (!pending) begin
        pending  = 1'b1;
        seenAddr = memAddr;
      end
      if (memAck) begin
        pending = 1'b0;
        chk("R13 address held until ack", {12'b0, memAddr}, {12'b0, seenAddr});
        if (memWe) begin
          if (expQ.size() == 0) begin
            chk("R4 unexpected write", {12'b0, memAddr}, 32'hFFFFFFFF);
          end else begin
            wrItem_t e;
            e = expQ.pop_front();
            chk({e.tag, " write address"}, {12'b0, memAddr}, {12'b0, e.addr});
            chk({e.tag, " write data"}, {24'b0, memWdata}, {24'b0, e.data});
          end
        end
      end
    end
  end

  task automatic runOp(input logic [2:0] op, input logic [1:0] rep,
                       input logic w, input logic dn,
                       input logic [15:0] sSeg, input logic [15:0] dSeg,
                       input logic [15:0] sOff, input logic [15:0] dOff,
                       input logic [15:0] cnt, input logic [15:0] ac,
                       output int lat);
    opSel = op; repSel = rep; wordMode = w; dirDown = dn;
    srcSeg = sSeg; dstSeg = dSeg; srcOffIn = sOff; dstOffIn = dOff;
    countIn = cnt; accIn = ac;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    chk("R14 done reached", {31'b0, done}, 32'd1);
    @(negedge clk);
    chk("R14 done is one pulse", {31'b0, done}, 32'd0);
    chk("R14 idle after done", {31'b0, busy}, 32'd0);
    chk("R4 scoreboard drained", expQ.size(), 32'd0);
  endtask

  task automatic chkFlags(string tag, logic z, logic c, logic s);
    chk({tag, " zf"}, {31'b0, zf}, {31'b0, z});
    chk({tag, " cf"}, {31'b0, cf}, {31'b0, c});
    chk({tag, " sf"}, {31'b0, sf}, {31'b0, s});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int lat;
    int acc0;
    rstN = 1'b0; start = 1'b0; opSel = '0; repSel = '0; wordMode = 1'b0;
    dirDown = 1'b0; srcSeg = '0; dstSeg = '0; srcOffIn = '0; dstOffIn = '0;
    countIn = '0; accIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk("R14 reset busy", {31'b0, busy}, 0);
    chk("R14 reset done", {31'b0, done}, 0);
    chk("R13 reset memReq", {31'b0, memReq}, 0);
    chk("R9 reset count", {16'b0, count}, 0);
    chkFlags("R5 reset", 0, 0, 0);

    // A: byte move upward, unconditional repeat
    for (int i = 0; i < 3; i++) begin
      mem[pa(16'h1000, 16'h0010 + 16'(i))] = 8'h30 + 8'(i);
      pushWr(pa(16'h2000, 16'h0020 + 16'(i)), 8'h30 + 8'(i), "R1 R4 byte move");
    end
    runOp(3'd0, 2'd1, 0, 0, 16'h1000, 16'h2000, 16'h0010, 16'h0020, 16'd3, 16'h0, lat);
    chk("R2 move src offset up", {16'b0, srcOff}, 32'h0013);
    chk("R2 move dst offset up", {16'b0, dstOff}, 32'h0023);
    chk("R10 move counter exhausted", {16'b0, count}, 0);
    chkFlags("R4 move flags", 0, 0, 0);

    // B: word move downward, destination wraps below zero
    mem[pa(16'h3000, 16'h0100)] = 8'hA1; mem[pa(16'h3000, 16'h0101)] = 8'hA2;
    mem[pa(16'h3000, 16'h00FE)] = 8'hB1; mem[pa(16'h3000, 16'h00FF)] = 8'hB2;
    pushWr(20'h40000, 8'hA1, "R3 word move low");
    pushWr(20'h40001, 8'hA2, "R3 word move high");
    pushWr(20'h4FFFE, 8'hB1, "R2 wrapped low");
    pushWr(20'h4FFFF, 8'hB2, "R2 wrapped high");
    runOp(3'd0, 2'd1, 1, 1, 16'h3000, 16'h4000, 16'h0100, 16'h0000, 16'd2, 16'h0, lat);
    chk("R2 word src down", {16'b0, srcOff}, 32'h00FC);
    chk("R2 word dst wraps", {16'b0, dstOff}, 32'hFFFC);
    chk("R10 word counter", {16'b0, count}, 0);

    // C: single word load, high byte wraps in segment, address truncates
    mem[20'h0FFEF] = 8'h5C;
    mem[20'hFFFF0] = 8'hE7;
    acc0 = accessCount;
    runOp(3'd3, 2'd0, 1, 0, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h1234, 16'd7, 16'h0000, lat);
    chk("R3 R1 R7 word load value", {16'b0, acc}, 32'hE75C);
    chk("R7 load src stepped", {16'b0, srcOff}, 32'h0001);
    chk("R7 load dst untouched", {16'b0, dstOff}, 32'h1234);
    chk("R9 single keeps counter", {16'b0, count}, 32'd7);
    chk("R3 two byte accesses", accessCount - acc0, 2);

    // D: byte compare while equal, mismatch at third element
    begin
      logic [7:0] s [4] = '{8'h41, 8'h42, 8'h43, 8'h44};
      logic [7:0] d [4] = '{8'h41, 8'h42, 8'h58, 8'h44};
      for (int i = 0; i < 4; i++) begin
        mem[pa(16'h1000, 16'h0200 + 16'(i))] = s[i];
        mem[pa(16'h2000, 16'h0300 + 16'(i))] = d[i];
      end
    end
    acc0 = accessCount;
    runOp(3'd1, 2'd2, 0, 0, 16'h1000, 16'h2000, 16'h0200, 16'h0300, 16'd4, 16'h0, lat);
    chk("R11 compare stopped on mismatch", {16'b0, count}, 32'd1);
    chk("R5 compare src stepped", {16'b0, srcOff}, 32'h0203);
    chk("R5 compare dst stepped", {16'b0, dstOff}, 32'h0303);
    chk("R11 compare read count", accessCount - acc0, 6);
    chkFlags("R5 source below", 0, 1, 1);

    // E: byte scan while not equal, match at fourth element
    begin
      logic [7:0] d [5] = '{8'h10, 8'h20, 8'h30, 8'h41, 8'h50};
      for (int i = 0; i < 5; i++) mem[pa(16'h5000, 16'h0010 + 16'(i))] = d[i];
    end
    runOp(3'd2, 2'd3, 0, 0, 16'h1000, 16'h5000, 16'hAAAA, 16'h0010, 16'd10, 16'h7741, lat);
    chk("R11 scan stopped on match", {16'b0, count}, 32'd6);
    chk("R6 scan dst stepped", {16'b0, dstOff}, 32'h0014);
    chk("R6 scan src untouched", {16'b0, srcOff}, 32'hAAAA);
    chk("R6 scan acc untouched", {16'b0, acc}, 32'h7741);
    chkFlags("R6 scan equal", 1, 0, 0);

    // F: byte store downward, flags preserved
    pushWr(pa(16'h6000, 16'h0005), 8'hAB, "R8 store");
    pushWr(pa(16'h6000, 16'h0004), 8'hAB, "R8 store");
    runOp(3'd4, 2'd1, 0, 1, 16'h1000, 16'h6000, 16'h5555, 16'h0005, 16'd2, 16'h12AB, lat);
    chk("R8 store dst stepped", {16'b0, dstOff}, 32'h0003);
    chk("R8 store src untouched", {16'b0, srcOff}, 32'h5555);
    chkFlags("R8 store keeps flags", 1, 0, 0);

    // G: single word compare, source above destination
    mem[pa(16'h7000, 16'h0000)] = 8'h90; mem[pa(16'h7000, 16'h0001)] = 8'h01;
    mem[pa(16'h8000, 16'h0000)] = 8'h10; mem[pa(16'h8000, 16'h0001)] = 8'h01;
    runOp(3'd1, 2'd0, 1, 0, 16'h7000, 16'h8000, 16'h0000, 16'h0000, 16'd9, 16'h0, lat);
    chkFlags("R5 source above", 0, 0, 0);
    chk("R9 single compare counter", {16'b0, count}, 32'd9);
    chk("R2 word compare step", {16'b0, dstOff}, 32'h0002);

    // H: word compare while not equal, equal at third element
    begin
      logic [15:0] s [3] = '{16'h1111, 16'h2222, 16'h3333};
      logic [15:0] d [3] = '{16'h1112, 16'h2223, 16'h3333};
      for (int i = 0; i < 3; i++) begin
        mem[pa(16'h7100, 16'(2*i))]     = s[i][7:0];
        mem[pa(16'h7100, 16'(2*i + 1))] = s[i][15:8];
        mem[pa(16'h8100, 16'(2*i))]     = d[i][7:0];
        mem[pa(16'h8100, 16'(2*i + 1))] = d[i][15:8];
      end
    end
    runOp(3'd1, 2'd3, 1, 0, 16'h7100, 16'h8100, 16'h0000, 16'h0000, 16'd5, 16'h0, lat);
    chk("R11 word compare stopped on equal", {16'b0, count}, 32'd2);
    chk("R11 word compare src", {16'b0, srcOff}, 32'h0006);
    chkFlags("R5 word equal", 1, 0, 0);

    // I: word scan while equal runs the counter out
    for (int i = 0; i < 3; i++) begin
      mem[pa(16'h9000, 16'(2*i))]     = 8'hEF;
      mem[pa(16'h9000, 16'(2*i + 1))] = 8'hBE;
    end
    runOp(3'd2, 2'd2, 1, 0, 16'h1000, 16'h9000, 16'h0000, 16'h0000, 16'd3, 16'hBEEF, lat);
    chk("R10 scan counter exhausted", {16'b0, count}, 0);
    chk("R6 word scan dst", {16'b0, dstOff}, 32'h0006);
    chkFlags("R6 word scan equal", 1, 0, 0);

    // J: repeated start with empty counter
    acc0 = accessCount;
    runOp(3'd0, 2'd1, 0, 0, 16'h1000, 16'h2000, 16'h0444, 16'h0555, 16'd0, 16'h0, lat);
    chk("R12 done one cycle after start", lat, 1);
    chk("R12 no memory access", accessCount - acc0, 0);
    chk("R12 offsets unchanged", {srcOff, dstOff}, 32'h04440555);

    // K: move under conditional mode ignores the condition
    mem[pa(16'h1000, 16'h0600)] = 8'h01; mem[pa(16'h1000, 16'h0601)] = 8'h02;
    pushWr(pa(16'h2000, 16'h0700), 8'h01, "R11 move ignores condition");
    pushWr(pa(16'h2000, 16'h0701), 8'h02, "R11 move ignores condition");
    runOp(3'd0, 2'd3, 0, 0, 16'h1000, 16'h2000, 16'h0600, 16'h0700, 16'd2, 16'h0, lat);
    chk("R11 move ran full count", {16'b0, count}, 0);

    // L: byte load downward keeps accumulator high byte
    mem[pa(16'h1000, 16'h0500)] = 8'h3C;
    runOp(3'd3, 2'd0, 0, 1, 16'h1000, 16'h2000, 16'h0500, 16'h0000, 16'd1, 16'h9900, lat);
    chk("R7 byte load keeps high", {16'b0, acc}, 32'h993C);
    chk("R2 byte load down", {16'b0, srcOff}, 32'h04FF);

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule